// File: doc/BRIEF.md
# Secure Feedback Scan Chain Segment

This block is a K-stage scan register meant to stand in for the part of an ordinary scan chain that holds secret state. In functional operation every stage loads its bit from the parallel data input, which comes from the surrounding combinational logic. In scan operation the stages shift serial data from the scan input toward the scan output. Between some stages an XOR gate adds a product of flip-flop states. Each such product reads only the stage it feeds and stages further down the chain. Because of these gates, the chain is not a plain shift register, and someone who treats it as one neither loads nor reads the intended values.

The structure is fixed at compile time by three parameters. A per-stage XOR enable chooses where the gates sit. A per-stage AND-term mask chooses which state bits feed each gate. A set of inverter flags places inverters in front of each stage and in front of the serial output. Stage 0 never carries a gate; it is the buffer flop that must sit between the serial input and the first gate. Mask bits that name a stage before the one being fed are dropped, so that the delayed output depends only on the state at the start of the window. With an inverter in front of stage 0, and one between the stage after the last gate and the output, neither scan-in nor scan-out matches a plain shift register.

The control has two operating states: **Capture** (scan-enable low) and **Shift** (scan-enable high). The block moves between them on every rising edge according to the scan-enable sampled there: Capture→Shift when it rises, Shift→Capture when it falls, and it stays in the current state otherwise.

Top module: `fbscan_segment`

## Requirements
- R1: A synchronous reset, taken on a rising edge, clears every stage to 0, whatever scan-enable is.
- R2: With scan-enable low, a rising edge loads parallel input bit i into stage i for every i.
- R3: With scan-enable high, stage 0 (par_out[0]) takes the serial input, inverted when inverter flag 0 is set.
- R4: Configuration A has K=3, an XOR before stage 1 fed by stage1·stage2, and no inverters. After three shifts starting from state y (y1=par_out[0], y2=par_out[1], y3=par_out[2]) with first input x, it gives scan_out = x ⊕ y1·y2 ⊕ y2·y3.
- R5: Configuration B is configuration A plus inverters before stage 0 and before stage 2. After three shifts it gives scan_out = x ⊕ y1 ⊕ y1·y2.
- R6: In configuration B, after one shift stage 0 holds the complement of the bit shifted in. In configuration A it holds that bit unchanged.
- R7: A stage with no XOR gate takes the previous stage on a shift, inverted when its inverter flag is set. In configuration A, one shift moves par_out[1] into par_out[2] unchanged. In configuration B it moves in complemented.
- R8: scan_out is the last stage XOR the output inverter flag (flag K), with no added register. In both configurations it equals par_out[2] at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| scan_en | input | 1 | 1 selects shift, 0 selects parallel capture |
| scan_in | input | 1 | Serial scan data input |
| scan_out | output | 1 | Serial scan data output |
| par_in | input | K | Parallel data from the combinational logic |
| par_out | output | K | Current state of the stages |

## Verification
The hardest cases to reach are the delayed output relations. They depend on the exact state at the start of a three-cycle shift window, and that state cannot be set through scan itself without knowing the structure. The stimulus therefore loads each of the eight start states with a parallel capture. It then shifts every one of the eight three-bit input sequences, which reaches every product-term combination. Two configurations that differ only in inverter placement run side by side, so the secure and insecure behaviours are checked against each other on the same stimulus.

// File: rtl/fbscan_pkg.sv
package fbscan_pkg;

    typedef enum logic {
        OP_CAPTURE = 1'b0,
        OP_SHIFT   = 1'b1
    } op_e;

    // Product over the selected state bits; an empty selection yields 1.
    function automatic logic and_term(input logic [31:0] st, input logic [31:0] sel);
        logic acc;
        acc = 1'b1;
        for (int j = 0; j < 32; j++) begin
            if (sel[j]) acc = acc & st[j];
        end
        return acc;
    endfunction

endpackage

// File: rtl/fbscan_feed.sv
module fbscan_feed
    import fbscan_pkg::*;
#(
    parameter int        K    = 3,
    parameter int        IDX  = 0,
    parameter logic      EN   = 1'b0,
    parameter logic [K-1:0] MASK = '0,
    parameter logic      INV  = 1'b0
) (
    input  logic [K-1:0] state_i,
    input  logic         prev_i,
    output logic         d_o
);
    localparam logic         EN_EFF  = (IDX == 0) ? 1'b0 : EN;
    localparam logic [K-1:0] LOW_BITS = (K'(1) << IDX) - K'(1);
    localparam logic [K-1:0] SEL      = MASK & ~LOW_BITS;

    logic term;

    always_comb begin
        term = EN_EFF & and_term(32'(state_i), 32'(SEL));
        d_o  = prev_i ^ INV ^ term;
    end

endmodule

// File: rtl/fbscan_cell.sv
module fbscan_cell (
    input  logic clk,
    input  logic rst,
    input  logic shift_i,
    input  logic pd_i,
    input  logic sd_i,
    output logic q_o
);
    always_ff @(posedge clk) begin
        if (rst)          q_o <= 1'b0;
        else if (shift_i) q_o <= sd_i;
        else              q_o <= pd_i;
    end
endmodule

// File: rtl/fbscan_segment.sv
module fbscan_segment
    import fbscan_pkg::*;
#(
    parameter int           K         = 3,
    parameter logic [K-1:0] XOR_EN    = 3'b010,
    parameter logic [K*K-1:0] TERM_MASK = 9'b000_110_000,
    parameter logic [K:0]   INV_POS   = 4'b0000
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         scan_en,
    input  logic         scan_in,
    output logic         scan_out,
    input  logic [K-1:0] par_in,
    output logic [K-1:0] par_out
);
    op_e          op;
    logic         shift_sel;
    logic [K-1:0] st;
    logic [K-1:0] src;
    logic [K-1:0] d_shift;

    always_comb begin
        op = scan_en ? OP_SHIFT : OP_CAPTURE;
        unique case (op)
            OP_SHIFT:   shift_sel = 1'b1;
            OP_CAPTURE: shift_sel = 1'b0;
            default:    shift_sel = 1'b0;
        endcase
    end

    assign src[0] = scan_in;

    for (genvar i = 0; i < K; i++) begin : g_stage
        if (i > 0) begin : g_src
            assign src[i] = st[i-1];
        end
        fbscan_feed #(
            .K(K), .IDX(i), .EN(XOR_EN[i]),
            .MASK(TERM_MASK[i*K +: K]), .INV(INV_POS[i])
        ) u_feed (
            .state_i(st), .prev_i(src[i]), .d_o(d_shift[i])
        );
        fbscan_cell u_cell (
            .clk(clk), .rst(rst), .shift_i(shift_sel),
            .pd_i(par_in[i]), .sd_i(d_shift[i]), .q_o(st[i])
        );
        if (i > 0 && !XOR_EN[i]) begin : g_plain
            AST_PLAIN_STAGE: assert property (@(posedge clk) disable iff (rst)
                scan_en |=> (st[i] == ($past(st[i-1]) ^ INV_POS[i]))); // R7
        end
    end

    always_comb begin
        scan_out = st[K-1] ^ INV_POS[K];
        par_out  = st;
    end

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (par_out == '0)); // R1
    AST_CAPTURE_LOAD: assert property (@(posedge clk) disable iff (rst)
        !scan_en |=> (par_out == $past(par_in))); // R2
    AST_HEAD_STAGE: assert property (@(posedge clk) disable iff (rst)
        scan_en |=> (par_out[0] == ($past(scan_in) ^ INV_POS[0]))); // R3
    AST_OUT_TAIL: assert property (@(posedge clk) disable iff (rst)
        ($past(par_out[K-1]) == $past(scan_out) ^ INV_POS[K])); // R8

endmodule

// File: tb/sim_fbscan_segment.sv
module sim_fbscan_segment;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scan_en = 1'b0;
    logic       scan_in = 1'b0;
    logic [2:0] par_in = '0;
    logic       so_a, so_b;
    logic [2:0] po_a, po_b;
    int         checks = 0;
    int         failures = 0;
    bit         done = 1'b0;

    always #5 clk = ~clk;

    fbscan_segment #(.K(3), .XOR_EN(3'b010), .TERM_MASK(9'b000_110_000),
                     .INV_POS(4'b0000)) u0 (
        .clk(clk), .rst(rst), .scan_en(scan_en), .scan_in(scan_in),
        .scan_out(so_a), .par_in(par_in), .par_out(po_a));

    fbscan_segment #(.K(3), .XOR_EN(3'b010), .TERM_MASK(9'b000_110_000),
                     .INV_POS(4'b0101)) u1 (
        .clk(clk), .rst(rst), .scan_en(scan_en), .scan_in(scan_in),
        .scan_out(so_b), .par_in(par_in), .par_out(po_b));

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #1;
        tick(); tick();
        chk(po_a == 3'b000 && po_b == 3'b000, "R1 reset state", po_a, 0);
        chk(so_a == 1'b0 && so_b == 1'b0, "R1 reset scan_out", so_b, 0);
        rst = 1'b0;
        for (int s = 0; s < 8; s++) begin
            for (int xs = 0; xs < 8; xs++) begin
                logic [2:0] y;
                logic x0, ea, eb;
                y = 3'(s);
                x0 = xs[0];
                scan_en = 1'b0; par_in = y;
                tick();
                chk(po_a == y && po_b == y, "R2 capture", po_b, y);
                scan_en = 1'b1; scan_in = x0;
                tick();
                chk(po_a[0] == x0, "R3 head stage A", po_a[0], x0);
                chk(po_b[0] == ~x0, "R6 head stage B inverted", po_b[0], ~x0);
                chk(po_a[2] == y[1], "R7 plain stage A", po_a[2], y[1]);
                chk(po_b[2] == ~y[1], "R7 plain stage B", po_b[2], ~y[1]);
                chk(so_a == po_a[2] && so_b == po_b[2], "R8 scan_out tail", so_b, po_b[2]);
                scan_in = xs[1];
                tick();
                scan_in = xs[2];
                tick();
                ea = x0 ^ (y[0] & y[1]) ^ (y[1] & y[2]);
                eb = x0 ^ y[0] ^ (y[0] & y[1]);
                chk(so_a == ea, "R4 delayed output A", so_a, ea);
                chk(so_b == eb, "R5 delayed output B", so_b, eb);
            end
        end
        scan_en = 1'b1; scan_in = 1'b1; rst = 1'b1;
        tick();
        chk(po_a == 3'b000 && po_b == 3'b000, "R1 reset during shift", po_b, 0);
        rst = 1'b0;
        tick();
        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule